// File: doc/BRIEF.md
# Ladder Rung Power-Flow Evaluator

This block works out whether power reaches the coil of one ladder-logic rung. A fetch unit feeds it the rung's contacts one instruction at a time. Each instruction carries a 4-bit branch attribute, a contact-type bit (normally open or normally closed) and the contact's status bit taken from the I/O image. The block keeps three 1-bit power registers: the running power, a branch result and a saved copy. It also keeps two 1-bit stacks, 4 entries deep. The branch stack holds the power at the node where a parallel group starts. The merge stack holds finished branch results until they are ORed back in.

A rung starts with a start strobe, which loads the running power with the hot rail (1) and empties both stacks. The engine then accepts instructions while `ready_o` is high. A rung-end strobe copies the running power to the coil output and pulses `done_o`. A stack misuse (a push onto a full stack, a pop or read from an empty one) sets a sticky error flag. The misuse leaves that stack's depth unchanged.

Top module: `rung_engine`

## Requirements
- R1: After reset `ready_o`=1, `done_o`=0, `coil_o`=0 and `stack_err_o`=0.
- R2: In the idle state (`ready_o`=1) the inputs are taken in this priority order: start, then rung end, then instruction. An accepted instruction holds `ready_o` low for exactly one cycle, and `ready_o` returns high on the next cycle.
- R3: An accepted start sets the running power to 1, empties both stacks and clears `stack_err_o`.
- R4: A contact conducts when `contact_st_i` XOR `contact_nc_i` is 1 (`contact_nc_i`=1 marks a normally closed contact). A non-conducting contact forces to 0 the power it passes on.
- R5: Attribute codes are 4'b0001 series, 4'b0010 branch-open (push running power onto the branch stack, then gate), 4'b0011 branch-return (push the running power onto the merge stack, reload it from the branch stack top, then gate), and 4'b0100 merge (gate, then OR in a value popped from the merge stack). Built from these codes, the coil equals the AND/OR function of the contacts in a series-parallel network.
- R6: Code 4'b0111 gates the power, pops the merge stack, ORs the popped value with the gated power, and pushes the result back onto the merge stack.
- R7: Code 4'b0101 pushes the running power onto the branch stack and then merges like 4'b0100.
- R8: Codes 4'b0110 and 4'b1000 gate the running power and leave both stacks unchanged. Code 4'b1000 also loads the saved register with the gated power.
- R9: Codes 4'b0000 and 4'b1001 to 4'b1111 change neither the power nor the stacks nor the error flag.
- R10: A push onto a full stack, or a pop or top read from an empty stack, sets `stack_err_o`. The flag stays set until the next start, and the failed operation leaves the stack depth and contents unchanged.
- R11: An accepted rung end loads `coil_o` with the running power on that edge. `done_o` is high for exactly that one following cycle. `coil_o` holds its value until the next rung end.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| start_i | input | 1 | Begin a new rung |
| instr_valid_i | input | 1 | Instruction present |
| attr_i | input | 4 | Branch attribute code |
| contact_nc_i | input | 1 | 1 = normally closed contact |
| contact_st_i | input | 1 | Contact status from the I/O image |
| rung_end_i | input | 1 | Close the rung and update the coil |
| ready_o | output | 1 | Engine idle, inputs accepted |
| done_o | output | 1 | Coil updated this cycle |
| coil_o | output | 1 | Rung result |
| stack_err_o | output | 1 | Sticky stack misuse flag |

## Verification
The assertions assume that strobes and instructions are offered only while `ready_o` is high, and that a rung always begins with a start strobe. They also assume that branch-return and merge codes appear only after an open has filled the stack they read. The stimulus respects all three. Every transaction waits for `ready_o`. Each random network is opened with a start. Random programs are built from a series prefix, two or three parallel branches and a series suffix, and each of these shapes keeps both stacks at a depth of at most one. Only the directed corner cases break these limits, and they do so on purpose to reach the overflow, underflow and illegal-code behaviour.

// File: rtl/rung_pkg.sv
package rung_pkg;
  localparam logic [3:0] ATTR_SER      = 4'd1;
  localparam logic [3:0] ATTR_OPEN     = 4'd2;
  localparam logic [3:0] ATTR_RET      = 4'd3;
  localparam logic [3:0] ATTR_UP       = 4'd4;
  localparam logic [3:0] ATTR_OPEN_UP  = 4'd5;
  localparam logic [3:0] ATTR_OPEN_RET = 4'd6;
  localparam logic [3:0] ATTR_RET_UP   = 4'd7;
  localparam logic [3:0] ATTR_ALL      = 4'd8;

  typedef enum logic [1:0] {PA_HOLD, PA_GATE, PA_RELOAD, PA_MERGE} pa_sel_e;
  typedef enum logic [2:0] {PB_HOLD, PB_POP, PB_GATE, PB_POPMERGE, PB_ACCUM} pb_sel_e;
  typedef enum logic {ST_IDLE, ST_EXEC} state_e;

  typedef struct packed {
    logic    legal;
    logic    br_push;
    logic    br_peek;
    logic    mg_push;
    logic    mg_pop;
    logic    mg_din_merge;
    pa_sel_e pa;
    pb_sel_e pb;
    logic    pc_load;
  } ctl_t;
endpackage

// File: rtl/rung_attr_decode.sv
module rung_attr_decode
  import rung_pkg::*;
(
  input  logic [3:0] attr_i,
  output ctl_t       ctl_o
);
  always_comb begin
    ctl_o = '{legal: 1'b1, br_push: 1'b0, br_peek: 1'b0, mg_push: 1'b0,
              mg_pop: 1'b0, mg_din_merge: 1'b0, pa: PA_GATE, pb: PB_HOLD,
              pc_load: 1'b0};
    case (attr_i)
      ATTR_SER: ;
      ATTR_OPEN: ctl_o.br_push = 1'b1;
      ATTR_RET: begin
        ctl_o.br_peek = 1'b1;
        ctl_o.mg_push = 1'b1;
        ctl_o.pa      = PA_RELOAD;
      end
      ATTR_UP: begin
        ctl_o.mg_pop = 1'b1;
        ctl_o.pa     = PA_MERGE;
        ctl_o.pb     = PB_POP;
      end
      ATTR_OPEN_UP: begin
        ctl_o.br_push = 1'b1;
        ctl_o.mg_pop  = 1'b1;
        ctl_o.pa      = PA_MERGE;
        ctl_o.pb      = PB_POP;
      end
      ATTR_OPEN_RET: ctl_o.pb = PB_GATE;
      ATTR_RET_UP: begin
        ctl_o.mg_pop       = 1'b1;
        ctl_o.mg_push      = 1'b1;
        ctl_o.mg_din_merge = 1'b1;
        ctl_o.pb           = PB_POPMERGE;
      end
      ATTR_ALL: begin
        ctl_o.pb      = PB_ACCUM;
        ctl_o.pc_load = 1'b1;
      end
      default: begin
        ctl_o.legal = 1'b0;
        ctl_o.pa    = PA_HOLD;
      end
    endcase
  end
endmodule

// File: rtl/rung_bit_stack.sv
module rung_bit_stack #(
  parameter int DEPTH = 4
) (
  input  logic clk,
  input  logic rst_n,
  input  logic clr_i,
  input  logic push_i,
  input  logic pop_i,
  input  logic peek_i,
  input  logic din_i,
  output logic top_o,
  output logic fault_o
);
  localparam int CW = $clog2(DEPTH + 1);
  localparam int AW = (DEPTH > 1) ? $clog2(DEPTH) : 1;

  logic [DEPTH-1:0] mem_q, mem_n;
  logic [CW-1:0]    cnt_q, cnt_n, cnt_m1;
  logic             empty, full;

  assign empty   = (cnt_q == '0);
  assign full    = (cnt_q == CW'(DEPTH));
  assign cnt_m1  = cnt_q - CW'(1);
  assign top_o   = empty ? 1'b0 : mem_q[cnt_m1[AW-1:0]];
  assign fault_o = ((pop_i | peek_i) & empty) | (push_i & ~pop_i & full);

  always_comb begin
    mem_n = mem_q;
    cnt_n = cnt_q;
    if (clr_i) begin
      mem_n = '0;
      cnt_n = '0;
    end else if (push_i && pop_i) begin
      if (!empty) mem_n[cnt_m1[AW-1:0]] = din_i;
    end else if (push_i) begin
      if (!full) begin
        mem_n[cnt_q[AW-1:0]] = din_i;
        cnt_n = cnt_q + CW'(1);
      end
    end else if (pop_i) begin
      if (!empty) cnt_n = cnt_m1;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      mem_q <= '0;
      cnt_q <= '0;
    end else begin
      mem_q <= mem_n;
      cnt_q <= cnt_n;
    end
  end

  AST_STACK_BOUND: assert property (@(posedge clk) disable iff (!rst_n)
    cnt_q <= CW'(DEPTH)); // R10
  AST_FULL_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    (push_i && !pop_i && full && !clr_i) |=> ($stable(cnt_q) && $stable(mem_q))); // R10
  AST_EMPTY_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    (pop_i && empty && !clr_i) |=> (cnt_q == '0)); // R10
endmodule

// File: rtl/rung_engine.sv
module rung_engine
  import rung_pkg::*;
#(
  parameter int STACK_DEPTH = 4
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       start_i,
  input  logic       instr_valid_i,
  input  logic [3:0] attr_i,
  input  logic       contact_nc_i,
  input  logic       contact_st_i,
  input  logic       rung_end_i,
  output logic       ready_o,
  output logic       done_o,
  output logic       coil_o,
  output logic       stack_err_o
);
  state_e     state_q, state_n;
  logic [3:0] attr_q;
  logic       cond_q;
  logic       pwra_q, pwra_n, pwrb_q, pwrb_n, pwrc_q, pwrc_n;
  logic       coil_q, coil_n, done_q, err_q, err_n;
  logic       start_acc, end_acc, ins_acc, exec;
  logic       gated, br_top, mg_top, br_fault, mg_fault, mg_din;
  ctl_t       ctl;

  assign ready_o   = (state_q == ST_IDLE);
  assign start_acc = ready_o & start_i;
  assign end_acc   = ready_o & ~start_i & rung_end_i;
  assign ins_acc   = ready_o & ~start_i & ~rung_end_i & instr_valid_i;
  assign exec      = (state_q == ST_EXEC);
  assign gated     = pwra_q & cond_q;
  assign mg_din    = ctl.mg_din_merge ? (gated | mg_top) : pwra_q;

  rung_attr_decode i_dec (.attr_i(attr_q), .ctl_o(ctl));

  rung_bit_stack #(.DEPTH(STACK_DEPTH)) i_br_stack (
    .clk(clk), .rst_n(rst_n), .clr_i(start_acc),
    .push_i(exec & ctl.br_push), .pop_i(1'b0), .peek_i(exec & ctl.br_peek),
    .din_i(pwra_q), .top_o(br_top), .fault_o(br_fault));

  rung_bit_stack #(.DEPTH(STACK_DEPTH)) i_mg_stack (
    .clk(clk), .rst_n(rst_n), .clr_i(start_acc),
    .push_i(exec & ctl.mg_push), .pop_i(exec & ctl.mg_pop), .peek_i(1'b0),
    .din_i(mg_din), .top_o(mg_top), .fault_o(mg_fault));

  always_comb begin
    state_n = ins_acc ? ST_EXEC : ST_IDLE;
    pwra_n  = pwra_q;
    pwrb_n  = pwrb_q;
    pwrc_n  = pwrc_q;
    if (start_acc) begin
      pwra_n = 1'b1;
      pwrb_n = 1'b0;
      pwrc_n = 1'b0;
    end else if (exec) begin
      case (ctl.pa)
        PA_GATE:   pwra_n = gated;
        PA_RELOAD: pwra_n = br_top & cond_q;
        PA_MERGE:  pwra_n = gated | mg_top;
        default:   ;
      endcase
      case (ctl.pb)
        PB_POP:      pwrb_n = mg_top;
        PB_GATE:     pwrb_n = gated;
        PB_POPMERGE: pwrb_n = gated | mg_top;
        PB_ACCUM:    pwrb_n = gated | pwrb_q;
        default:     ;
      endcase
      if (ctl.pc_load) pwrc_n = gated;
    end
    coil_n = end_acc ? pwra_q : coil_q;
    err_n  = start_acc ? 1'b0 : (err_q | (exec & (br_fault | mg_fault)));
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_q <= ST_IDLE;
      attr_q  <= '0;
      cond_q  <= 1'b0;
      pwra_q  <= 1'b1;
      pwrb_q  <= 1'b0;
      pwrc_q  <= 1'b0;
      coil_q  <= 1'b0;
      done_q  <= 1'b0;
      err_q   <= 1'b0;
    end else begin
      state_q <= state_n;
      if (ins_acc) begin
        attr_q <= attr_i;
        cond_q <= contact_st_i ^ contact_nc_i;
      end
      pwra_q <= pwra_n;
      pwrb_q <= pwrb_n;
      pwrc_q <= pwrc_n;
      coil_q <= coil_n;
      done_q <= end_acc;
      err_q  <= err_n;
    end
  end

  assign coil_o      = coil_q;
  assign done_o      = done_q;
  assign stack_err_o = err_q;

  AST_EXEC_ONE_CYCLE: assert property (@(posedge clk) disable iff (!rst_n)
    exec |=> ready_o); // R2
  AST_START_INIT: assert property (@(posedge clk) disable iff (!rst_n)
    start_acc |=> (pwra_q && !stack_err_o)); // R3
  AST_ILLEGAL_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    (exec && !ctl.legal) |=> ($stable(pwra_q) && $stable(stack_err_o))); // R9
  AST_PC_TRACK: assert property (@(posedge clk) disable iff (!rst_n)
    (exec && ctl.pc_load) |=> (pwrc_q == pwra_q)); // R8
  AST_ERR_STICKY: assert property (@(posedge clk) disable iff (!rst_n)
    (stack_err_o && !start_acc) |=> stack_err_o); // R10
  AST_DONE_PULSE: assert property (@(posedge clk) disable iff (!rst_n)
    done_o |=> !done_o); // R11
  AST_COIL_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    !end_acc |=> $stable(coil_o)); // R11
endmodule

// File: tb/test_rung_engine.sv
module test_rung_engine;
  localparam int CLK_PERIOD = 10;

  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       start_i = 1'b0, instr_valid_i = 1'b0, rung_end_i = 1'b0;
  logic [3:0] attr_i = 4'd0;
  logic       contact_nc_i = 1'b0, contact_st_i = 1'b0;
  logic       ready_o, done_o, coil_o, stack_err_o;

  int checks = 0;
  int errors = 0;
  bit finished = 1'b0;

  always #(CLK_PERIOD/2) clk = ~clk;

  rung_engine i_rung_engine (
    .clk(clk), .rst_n(rst_n), .start_i(start_i), .instr_valid_i(instr_valid_i),
    .attr_i(attr_i), .contact_nc_i(contact_nc_i), .contact_st_i(contact_st_i),
    .rung_end_i(rung_end_i), .ready_o(ready_o), .done_o(done_o),
    .coil_o(coil_o), .stack_err_o(stack_err_o));

  task automatic check(input bit actual, input bit expected, input string tag);
    checks++;
    if (actual !== expected) begin
      errors++;
      $display("FAIL %s actual=%0b expected=%0b", tag, actual, expected);
    end
  endtask

  task automatic wait_ready();
    @(negedge clk);
    while (!ready_o) @(negedge clk);
  endtask

  task automatic begin_rung();
    wait_ready();
    start_i = 1'b1;
    @(negedge clk);
    start_i = 1'b0;
  endtask

  task automatic send(input logic [3:0] a, input bit nc, input bit st);
    wait_ready();
    attr_i = a; contact_nc_i = nc; contact_st_i = st; instr_valid_i = 1'b1;
    @(negedge clk);
    instr_valid_i = 1'b0;
  endtask

  task automatic close_rung(input bit exp_coil, input string tag);
    wait_ready();
    rung_end_i = 1'b1;
    @(negedge clk);
    rung_end_i = 1'b0;
    check(done_o, 1'b1, {tag, " done"});
    check(coil_o, exp_coil, {tag, " coil"});
    @(negedge clk);
    check(done_o, 1'b0, "R11 done one cycle");
  endtask

  function automatic bit eval_net(input bit pre, input bit [2:0][2:0] c,
                                  input int nb, input int len[3], input bit suf);
    bit any = 1'b0;
    for (int b = 0; b < nb; b++) begin
      bit br = 1'b1;
      for (int k = 0; k < len[b]; k++) br &= c[b][k];
      any |= br;
    end
    return pre & any & suf;
  endfunction

  initial begin
    #(CLK_PERIOD * 100000);
    if (!finished) begin
      errors++;
      $display("FAIL watchdog expired");
      $display("  CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  initial begin
    void'($urandom(32'd4711));
    repeat (3) @(negedge clk);
    check(ready_o, 1'b1, "R1 ready");
    check(done_o, 1'b0, "R1 done");
    check(coil_o, 1'b0, "R1 coil");
    check(stack_err_o, 1'b0, "R1 err");
    rst_n = 1'b1;

    // R2: busy for one cycle after an instruction
    begin_rung();
    attr_i = 4'd1; contact_st_i = 1'b1; instr_valid_i = 1'b1;
    @(negedge clk);
    instr_valid_i = 1'b0;
    check(ready_o, 1'b0, "R2 busy");
    @(negedge clk);
    check(ready_o, 1'b1, "R2 ready again");
    // R2: start beats rung end
    start_i = 1'b1; rung_end_i = 1'b1;
    @(negedge clk);
    start_i = 1'b0; rung_end_i = 1'b0;
    check(done_o, 1'b0, "R2 start priority");

    // R4: normally closed contacts
    begin_rung(); send(4'd1, 1'b1, 1'b0); close_rung(1'b1, "R4 nc open");
    begin_rung(); send(4'd1, 1'b1, 1'b1); close_rung(1'b0, "R4 nc held");
    begin_rung(); send(4'd1, 1'b0, 1'b0); close_rung(1'b0, "R4 no off");

    // R6: merged value pushed back
    begin_rung();
    send(4'd2, 0, 1); send(4'd1, 0, 0); send(4'd3, 0, 1);
    send(4'd7, 0, 1); send(4'd1, 0, 0); send(4'd4, 0, 0);
    close_rung(1'b1, "R6 ret-up");
    check(stack_err_o, 1'b0, "R6 no err");

    // R7: open-up pushes branch stack
    begin_rung();
    send(4'd2, 0, 1); send(4'd1, 0, 1); send(4'd3, 0, 0);
    send(4'd5, 0, 1); send(4'd3, 0, 1);
    close_rung(1'b0, "R7 open-up");

    // R8: open-return and all-three gate only
    begin_rung(); send(4'd2, 0, 1); send(4'd6, 0, 0); close_rung(1'b0, "R8 open-ret gate");
    begin_rung(); send(4'd2, 0, 1); send(4'd8, 0, 1); close_rung(1'b1, "R8 all keep");
    check(stack_err_o, 1'b0, "R8 no stack use");

    // R9: illegal codes ignored
    begin_rung(); send(4'd1, 0, 1); send(4'd0, 0, 0); send(4'd15, 0, 0);
    close_rung(1'b1, "R9 illegal");
    check(stack_err_o, 1'b0, "R9 err");

    // R10: overflow keeps depth and contents
    begin_rung();
    send(4'd2, 0, 1); send(4'd2, 0, 1); send(4'd2, 0, 1);
    send(4'd2, 0, 0); send(4'd2, 0, 1); send(4'd3, 0, 1);
    close_rung(1'b1, "R10 overflow top");
    check(stack_err_o, 1'b1, "R10 overflow err");
    // R10: underflow
    begin_rung();
    check(stack_err_o, 1'b0, "R3 err cleared");
    send(4'd4, 0, 1);
    close_rung(1'b1, "R10 underflow power");
    check(stack_err_o, 1'b1, "R10 underflow err");
    // R3: start empties stacks
    begin_rung(); send(4'd2, 0, 1);
    close_rung(1'b1, "R3 fresh");
    check(stack_err_o, 1'b0, "R3 no err");

    // R5: random series-parallel networks
    for (int t = 0; t < 60; t++) begin
      bit pre, suf, pre_nc, suf_nc, exp_v;
      bit [2:0][2:0] eff;
      int nb;
      int len[3];
      bit use_pre, use_suf;
      nb = 2 + int'($urandom_range(1));
      use_pre = $urandom_range(1) != 0;
      use_suf = $urandom_range(1) != 0;
      for (int b = 0; b < 3; b++) len[b] = (b == 0) ? 1 + int'($urandom_range(2)) : 2 + int'($urandom_range(1));
      begin_rung();
      pre = 1'b1; suf = 1'b1;
      if (use_pre) begin
        bit s = $urandom_range(1) != 0;
        pre_nc = $urandom_range(1) != 0;
        pre = s ^ pre_nc;
        send(4'd1, pre_nc, s);
      end
      for (int b = 0; b < nb; b++) begin
        for (int k = 0; k < len[b]; k++) begin
          bit s = $urandom_range(1) != 0;
          bit n = $urandom_range(3) == 0;
          logic [3:0] a;
          eff[b][k] = s ^ n;
          if (k == 0) a = (b == 0) ? 4'd2 : 4'd3;
          else if (b != 0 && k == len[b] - 1) a = 4'd4;
          else a = 4'd1;
          send(a, n, s);
        end
      end
      if (use_suf) begin
        bit s = $urandom_range(1) != 0;
        suf_nc = $urandom_range(1) != 0;
        suf = s ^ suf_nc;
        send(4'd1, suf_nc, s);
      end
      exp_v = eval_net(pre, eff, nb, len, suf);
      close_rung(exp_v, "R5 network");
      check(stack_err_o, 1'b0, "R5 no err");
    end

    finished = 1'b1;
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule